// File: doc/BRIEF.md
# Network reference clock selector

This block picks one timing reference out of a set of candidates and conditions it for distribution. The candidates are an internal oscillator (direct or divided by eight), two shared network reference lines and a group of local references. The picked signal can be inverted and can be routed out through an external dejitter loop before a programmable divide-by-N stage. The divided result can be driven onto either or both shared reference lines, and a local routed reference is made available to on-chip clock consumers.

All reference signals are treated as data and sampled by one system clock. Every output is registered. Software sets the behaviour through a control register and a divisor register on a small register bus. The control register holds the source code, the invert bit, the dejitter bypass bit and the two-bit line mode. The divisor register holds N.

Top module: `netref_clk_sel`

## Requirements
- R1: Control bits 3:0 choose the source: 0001 the oscillator input, 0010 line 1 input, 0011 line 2 input, and 1000 to 1111 local references 0 to 7 in that order.
- R2: Source code 0000 selects the oscillator divided by eight. With an oscillator period of P clocks, the selector output period is 8P clocks.
- R3: A reserved source code from 0100 to 0111 holds the selector output at 0, whatever the invert bit is.
- R4: When control bit 4 is 1, a non-reserved selector output is inverted. When it is 0, the selector output is passed unchanged.
- R5: When control bit 5 is 0, the to-dejitter pin carries the selector output and the divider input is the from-dejitter pin. When bit 5 is 1, the to-dejitter pin is 0 and the divider input is the selector output.
- R6: Control bit 7 enables line 1 as an output and bit 6 enables line 2. An enabled line carries the divider output. A line that is not enabled has data 0.
- R7: The local routed reference depends on bits 7:6. Mode 00 gives the selector output, 01 the line 1 input, 10 the line 2 input and 11 the divider output.
- R8: A divisor of 0 or 1 passes the divider input through unchanged. A divisor N of 2 or more gives an output whose period is N input periods.
- R9: Bus address 0 is the control register and address 1 is the divisor. Both reset to 0x00. A write takes effect at the clock edge. Read data shows the addressed register exactly as written, reserved codes included, one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 divisor |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| osc_in | input | 1 | Internal oscillator |
| line1_in | input | 1 | Network reference line 1, receive side |
| line2_in | input | 1 | Network reference line 2, receive side |
| lref_in | input | NUM_LREF | Local references |
| dj_from | input | 1 | Return from the external dejitter loop |
| dj_to | output | 1 | Feed to the external dejitter loop |
| line1_oe | output | 1 | Line 1 output enable |
| line1_out | output | 1 | Line 1 drive data |
| line2_oe | output | 1 | Line 2 output enable |
| line2_out | output | 1 | Line 2 drive data |
| lsc_out | output | 1 | Local routed reference |

## Verification
The bench builds the block with its default parameters: eight local references and an 8-bit divisor. With a divisor of 1 the whole path becomes combinational from the bench's point of view, so every control value except source 0000 can be swept with four static input patterns. That sweep covers every source code, both invert settings, both dejitter settings and all four line modes. Toggling inputs then bring the dynamic paths within reach. The oscillator divide-by-eight path and divisors 0 to 9 are checked by measuring the distance between rising edges of the local reference.

// File: rtl/nref_pkg.sv
package nref_pkg;

  typedef enum logic [1:0] {
    NR_MODE_LOCAL = 2'b00,
    NR_MODE_L1IN  = 2'b01,
    NR_MODE_L2IN  = 2'b10,
    NR_MODE_BOTH  = 2'b11
  } nr_mode_e;

  typedef struct packed {
    nr_mode_e   mode;
    logic       dj_bypass;
    logic       invert;
    logic [3:0] src;
  } nr_ctrl_t;

  localparam logic [3:0] SRC_OSC_DIV = 4'b0000;
  localparam logic [3:0] SRC_OSC     = 4'b0001;
  localparam logic [3:0] SRC_LINE1   = 4'b0010;
  localparam logic [3:0] SRC_LINE2   = 4'b0011;

endpackage

// File: rtl/nref_regs.sv
module nref_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [7:0]    ctrl,
  output logic [DW-1:0] div_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      div_n <= '0;
      rdata <= '0;
    end else begin
      if (wr && !addr) ctrl  <= wdata[7:0];
      if (wr &&  addr) div_n <= wdata;
      rdata <= addr ? div_n : DW'(ctrl);
    end
  end

endmodule

// File: rtl/nref_src_sel.sv
module nref_src_sel #(
  parameter int NUM_LREF  = 8,
  parameter int OSC_DIV_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                osc_in,
  input  logic                line1_in,
  input  logic                line2_in,
  input  logic [NUM_LREF-1:0] lref_in,
  input  logic [3:0]          src,
  input  logic                invert,
  output logic                sel_out
);
  import nref_pkg::*;

  localparam int LREF_SLOTS = 8;

  logic                 osc_d1;
  logic [OSC_DIV_W-1:0] osc_cnt;
  logic [LREF_SLOTS-1:0] lref_pad;
  logic                 raw;
  logic                 reserved;

  // free-running oscillator prescaler, advanced on each oscillator rise
  always_ff @(posedge clk) begin
    if (rst) begin
      osc_d1  <= 1'b0;
      osc_cnt <= '0;
    end else begin
      osc_d1 <= osc_in;
      if (osc_in && !osc_d1) osc_cnt <= osc_cnt + 1'b1;
    end
  end

  always_comb begin
    lref_pad = '0;
    lref_pad[NUM_LREF-1:0] = lref_in;
  end

  always_comb begin
    reserved = 1'b0;
    raw      = 1'b0;
    if (src[3]) begin
      raw = lref_pad[src[2:0]];
    end else begin
      case (src)
        SRC_OSC_DIV: raw = osc_cnt[OSC_DIV_W-1];
        SRC_OSC:     raw = osc_in;
        SRC_LINE1:   raw = line1_in;
        SRC_LINE2:   raw = line2_in;
        default:     reserved = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sel_out <= 1'b0;
    else     sel_out <= reserved ? 1'b0 : (raw ^ invert);
  end

endmodule

// File: rtl/nref_div.sv
module nref_div #(
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic [NW-1:0] n,
  output logic          dout
);

  logic          din_d;
  logic [NW-1:0] cnt;
  logic [NW-1:0] half;
  logic          pass;

  assign half = n >> 1;
  assign pass = (n < NW'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      din_d <= 1'b0;
      cnt   <= '0;
      dout  <= 1'b0;
    end else begin
      din_d <= din;
      if (din && !din_d) begin
        if (pass || cnt >= n - 1'b1) cnt <= '0;
        else                          cnt <= cnt + 1'b1;
      end
      dout <= pass ? din_d : (cnt < half);
    end
  end

endmodule

// File: rtl/netref_clk_sel.sv
module netref_clk_sel #(
  parameter int NUM_LREF = 8,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_addr,
  input  logic [DIV_W-1:0]    reg_wdata,
  output logic [DIV_W-1:0]    reg_rdata,
  input  logic                osc_in,
  input  logic                line1_in,
  input  logic                line2_in,
  input  logic [NUM_LREF-1:0] lref_in,
  input  logic                dj_from,
  output logic                dj_to,
  output logic                line1_oe,
  output logic                line1_out,
  output logic                line2_oe,
  output logic                line2_out,
  output logic                lsc_out
);
  import nref_pkg::*;

  logic [7:0]       ctrl_q;
  nr_ctrl_t         ctrl;
  logic [DIV_W-1:0] div_n;
  logic             sel_out;
  logic             dj_from_q;
  logic             div_in;
  logic             div_out;
  logic             lsc_d;

  assign ctrl = nr_ctrl_t'(ctrl_q);

  nref_regs #(.DW(DIV_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl  (ctrl_q),
    .div_n (div_n)
  );

  nref_src_sel #(.NUM_LREF(NUM_LREF), .OSC_DIV_W(3)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .osc_in   (osc_in),
    .line1_in (line1_in),
    .line2_in (line2_in),
    .lref_in  (lref_in),
    .src      (ctrl.src),
    .invert   (ctrl.invert),
    .sel_out  (sel_out)
  );

  assign div_in = ctrl.dj_bypass ? sel_out : dj_from_q;

  nref_div #(.NW(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .din  (div_in),
    .n    (div_n),
    .dout (div_out)
  );

  always_comb begin
    case (ctrl.mode)
      NR_MODE_LOCAL: lsc_d = sel_out;
      NR_MODE_L1IN:  lsc_d = line1_in;
      NR_MODE_L2IN:  lsc_d = line2_in;
      default:       lsc_d = div_out;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dj_from_q <= 1'b0;
      dj_to     <= 1'b0;
      line1_oe  <= 1'b0;
      line1_out <= 1'b0;
      line2_oe  <= 1'b0;
      line2_out <= 1'b0;
      lsc_out   <= 1'b0;
    end else begin
      dj_from_q <= dj_from;
      dj_to     <= sel_out & ~ctrl.dj_bypass;
      line1_oe  <= ctrl.mode[1];
      line1_out <= ctrl.mode[1] & div_out;
      line2_oe  <= ctrl.mode[0];
      line2_out <= ctrl.mode[0] & div_out;
      lsc_out   <= lsc_d;
    end
  end

endmodule

// File: rtl/nref_checker.sv
module nref_checker (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [7:0] ctrl_q,
  input logic       div_out,
  input logic       dj_to,
  input logic       line1_oe,
  input logic       line1_out,
  input logic       line2_oe,
  input logic       line2_out,
  input logic       lsc_out
);

  a_r6_line1_enable: assert property (@(posedge clk) disable iff (rst)
    line1_oe == $past(ctrl_q[7]));

  a_r6_line2_enable: assert property (@(posedge clk) disable iff (rst)
    line2_oe == $past(ctrl_q[6]));

  a_r6_idle_lines_quiet: assert property (@(posedge clk) disable iff (rst)
    (!line1_oe |-> !line1_out) and (!line2_oe |-> !line2_out));

  a_r5_bypass_dj_low: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_q[5]) |-> !dj_to);

  a_r7_both_gets_divider: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_q[7:6]) == 2'b11) |-> (lsc_out == $past(div_out)));

  a_r9_ctrl_holds: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_wr) |-> $stable(ctrl_q));

endmodule

bind netref_clk_sel nref_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .ctrl_q    (ctrl_q),
  .div_out   (div_out),
  .dj_to     (dj_to),
  .line1_oe  (line1_oe),
  .line1_out (line1_out),
  .line2_oe  (line2_oe),
  .line2_out (line2_out),
  .lsc_out   (lsc_out)
);

// File: tb/netref_clk_sel_tb.sv
`timescale 1ns/1ps
module netref_clk_sel_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       osc_in = 1'b0;
  logic       line1_in = 1'b0;
  logic       line2_in = 1'b0;
  logic [7:0] lref_in = '0;
  logic       dj_from = 1'b0;
  logic       dj_to, line1_oe, line1_out, line2_oe, line2_out, lsc_out;

  int  n_vec = 0;
  int  n_bad = 0;
  int  cyc = 0;
  bit  osc_run = 0;
  bit  lref_run = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  netref_clk_sel u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .osc_in(osc_in),
    .line1_in(line1_in), .line2_in(line2_in), .lref_in(lref_in),
    .dj_from(dj_from), .dj_to(dj_to), .line1_oe(line1_oe),
    .line1_out(line1_out), .line2_oe(line2_oe), .line2_out(line2_out),
    .lsc_out(lsc_out)
  );

  // stimulus togglers: oscillator period 2 clocks, local ref 3 period 4 clocks
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (osc_run) osc_in <= ~osc_in;
    if (lref_run && cyc[0]) lref_in[3] <= ~lref_in[3];
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(bit a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic rd_reg(bit a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // clocks between consecutive rising edges of lsc_out
  task automatic lsc_period(output int p);
    int  t0 = -1;
    int  k = 0;
    logic prev;
    p = -1;
    @(negedge clk);
    prev = lsc_out;
    while (k < 2000) begin
      @(negedge clk);
      k++;
      if (lsc_out && !prev) begin
        if (t0 < 0) t0 = k;
        else begin p = k - t0; break; end
      end
      prev = lsc_out;
    end
  endtask

  function automatic string lsc_tag(logic [1:0] m);
    if (m == 2'b00) return "R1/R3/R4 local from selector";
    return "R7 local routing";
  endfunction

  initial begin
    logic [7:0] rd;
    int p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check("R9 reset oe", {line1_oe, line2_oe}, 0);
    check("R6 reset line data", {line1_out, line2_out}, 0);
    rd_reg(0, rd); check("R9 reset ctrl", rd, 0);
    rd_reg(1, rd); check("R9 reset divisor", rd, 0);

    wr_reg(1, 8'd1);
    rd_reg(1, rd); check("R9 divisor readback", rd, 1);

    // static sweep over every control value with a static source
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cv = 8'(c);
      if (cv[3:0] == 4'b0000) continue;
      wr_reg(0, cv);
      rd_reg(0, rd); check("R9 ctrl readback", rd, int'(cv));
      for (int k = 0; k < 4; k++) begin
        logic s, raw, divin, e_lsc;
        logic [7:0] pat;
        logic [1:0] kb = 2'(k);
        case (k)
          0: pat = 8'hA5;
          1: pat = 8'h5A;
          2: pat = 8'h0F;
          default: pat = 8'hF0;
        endcase
        @(negedge clk);
        osc_in = kb[0]; line1_in = kb[1]; line2_in = ~kb[0];
        dj_from = kb[0] ^ kb[1]; lref_in = pat;
        repeat (6) @(negedge clk);
        case (cv[3:0])
          4'b0001: raw = osc_in;
          4'b0010: raw = line1_in;
          4'b0011: raw = line2_in;
          default: raw = cv[3] ? pat[cv[2:0]] : 1'b0;
        endcase
        if (cv[3:2] == 2'b01) s = 1'b0;
        else s = raw ^ cv[4];
        divin = cv[5] ? s : dj_from;
        case (cv[7:6])
          2'b00: e_lsc = s;
          2'b01: e_lsc = line1_in;
          2'b10: e_lsc = line2_in;
          default: e_lsc = divin;
        endcase
        check(lsc_tag(cv[7:6]), lsc_out, e_lsc);
        check("R5 to-dejitter pin", dj_to, cv[5] ? 0 : s);
        check("R6 line enables", {line1_oe, line2_oe}, cv[7:6]);
        check("R6 line data", {line1_out, line2_out},
              {cv[7] & divin, cv[6] & divin});
      end
    end

    // oscillator prescaler, bypass, both lines out
    osc_in = 1'b0; osc_run = 1;
    wr_reg(0, 8'h20);
    repeat (40) @(negedge clk);
    lsc_period(p); check("R2 osc/8 at local output", p, 16);
    wr_reg(0, 8'hE0);
    repeat (40) @(negedge clk);
    lsc_period(p); check("R2 osc/8 through divider N=1", p, 16);
    wr_reg(1, 8'd3);
    repeat (120) @(negedge clk);
    lsc_period(p); check("R8 osc/8 divided by 3", p, 48);
    osc_run = 0;

    // divider sweep on local ref 3, period 4 clocks
    lref_in = '0; lref_run = 1;
    wr_reg(0, 8'hEB);
    for (int n = 0; n < 10; n++) begin
      wr_reg(1, 8'(n));
      repeat (100) @(negedge clk);
      lsc_period(p);
      check("R8 divider period", p, 4 * ((n < 2) ? 1 : n));
    end
    // same path through the dejitter loop: loop return held low stops output
    wr_reg(1, 8'd2);
    wr_reg(0, 8'hCB);
    dj_from = 1'b0;
    repeat (20) @(negedge clk);
    lsc_period(p); check("R5 divider fed by loop return", p, -1);
    lref_run = 0;

    done = 1;
    summary();
  end

endmodule